// File: doc/BRIEF.md
# Page Write Buffer and Program Sequencer

This block sits behind the serial front end of a small byte-wide nonvolatile memory. The front end opens a write transfer with the start address, then hands over each received data byte as a one-cycle strobe. The block accepts bytes into a small page buffer and reports per strobe whether the byte is acknowledged. A stop indication closes the transfer.

On the stop, the block runs a self-timed program cycle. Each buffered byte takes one fixed time unit, and the bytes are written one after another through an array write port. Busy stays high for the whole cycle, and the front end uses it to withhold acknowledges.

Two parameters set the variant. The page depth is a power of two. The overflow policy is either wrap-and-overwrite or abort. A write-protect input can fence off the upper half of the address space.

Top module: `page_prog_seq`

## Requirements
- R1: A pulse on `xfer_start` loads `start_addr`. Each accepted byte is then programmed, in arrival order, to consecutive addresses starting at `start_addr`. Programming begins only after `stop`.
- R2: A transfer with one data byte before `stop` produces exactly one array write, and busy lasts one time unit.
- R3: With N bytes held, busy is high for exactly N*`TICKS_PER_BYTE` cycles, starting the cycle after `stop` is sampled. `mem_we` is asserted only while busy is high.
- R4: The program address increments only in its low log2(`PAGE_BYTES`) bits and wraps within them. The upper address bits keep the value of `start_addr`.
- R5: When `OVF_WRAP`=1, every strobe is acknowledged. Byte k lands in page slot k mod `PAGE_BYTES`, so later bytes overwrite earlier ones. N saturates at `PAGE_BYTES`.
- R6: When `OVF_WRAP`=0, the strobe after the page is full is not acknowledged and the transfer is aborted. No later strobe is acknowledged, and the following `stop` starts no program cycle: busy stays low and nothing is written.
- R7: A `stop` with no accepted byte leaves busy low and writes nothing.
- R8: When `PROT_EN`=1 and `wp` is high, a byte whose address has its top bit set is not written. The other bytes are written in their normal time units, and busy length is unchanged.
- R9: While busy is high, and in the single cycle right after it falls, `xfer_start` and data strobes are ignored, and no strobe is acknowledged.
- R10: After reset, `busy`, `mem_we` and `data_ack` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| xfer_start | input | 1 | Opens a write transfer and loads the start address |
| start_addr | input | ADDR_W | First array address of the transfer |
| data_vld | input | 1 | One-cycle strobe for a received data byte |
| data_in | input | 8 | Received data byte |
| stop | input | 1 | Closes the transfer |
| wp | input | 1 | Write-protect request for the upper half |
| data_ack | output | 1 | The current strobe is accepted |
| busy | output | 1 | Program cycle in progress |
| mem_we | output | 1 | Array write enable |
| mem_addr | output | ADDR_W | Array write address |
| mem_wdata | output | 8 | Array write data |

## Verification
The case that is hardest to reach from the ports is a start request that falls in the single idle cycle after busy drops. The bench watches busy at every falling clock edge. In the same half cycle in which it sees busy low, it drives `xfer_start` and then a data strobe, and expects no acknowledge and no array change. Overflow beyond the page depth is exercised against two instances driven in lockstep, one of each overflow variant. Random lengths of up to eleven bytes, random start offsets and random `wp` are mixed with directed wrap and abort cases.

// File: rtl/page_prog_seq.sv
module page_prog_seq #(
  parameter int ADDR_W         = 9,
  parameter int PAGE_BYTES     = 8,
  parameter int OVF_WRAP       = 1,
  parameter int PROT_EN        = 1,
  parameter int TICKS_PER_BYTE = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xfer_start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic              data_vld,
  input  logic [7:0]        data_in,
  input  logic              stop,
  input  logic              wp,
  output logic              data_ack,
  output logic              busy,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_wdata
);
  localparam int LO_W = (PAGE_BYTES > 1) ? $clog2(PAGE_BYTES) : 1;
  localparam int CNT_W = $clog2(PAGE_BYTES + 1);
  localparam int TK_W = $clog2(TICKS_PER_BYTE + 1);
  localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(PAGE_BYTES);
  localparam logic [TK_W-1:0] TK_LAST = TK_W'(TICKS_PER_BYTE - 1);

  typedef enum logic [1:0] {S_IDLE, S_COLL, S_PROG, S_GAP} st_t;

  st_t               st;
  logic [ADDR_W-1:0] base_q;
  logic [LO_W-1:0]   slot_q, idx_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [TK_W-1:0]   tk_q;
  logic              abort_q;
  logic [7:0]        pg_mem [PAGE_BYTES];

  logic full, over, in_coll, pg_we, unit_end, last_byte, prot_hit;
  logic [LO_W-1:0] lo_sum;

  assign full      = (cnt_q == CNT_FULL);
  assign over      = full && (OVF_WRAP == 0);
  assign in_coll   = (st == S_COLL) && !xfer_start && !stop;
  assign data_ack  = in_coll && data_vld && !abort_q && !over;
  assign pg_we     = data_ack;
  assign busy      = (st == S_PROG);
  assign unit_end  = busy && (tk_q == TK_LAST);
  assign last_byte = ({{(CNT_W-LO_W){1'b0}}, idx_q} + CNT_W'(1)) == cnt_q;
  assign lo_sum    = base_q[LO_W-1:0] + idx_q;
  assign mem_addr  = {base_q[ADDR_W-1:LO_W], lo_sum};
  assign prot_hit  = (PROT_EN != 0) && wp && mem_addr[ADDR_W-1];
  assign mem_we    = unit_end && !prot_hit;
  assign mem_wdata = pg_mem[idx_q];

  always_ff @(posedge clk) begin
    if (pg_we) pg_mem[slot_q] <= data_in;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st      <= S_IDLE;
      base_q  <= '0;
      slot_q  <= '0;
      idx_q   <= '0;
      cnt_q   <= '0;
      tk_q    <= '0;
      abort_q <= 1'b0;
    end else begin
      case (st)
        S_IDLE, S_COLL: begin
          if (xfer_start) begin
            st      <= S_COLL;
            base_q  <= start_addr;
            slot_q  <= '0;
            cnt_q   <= '0;
            abort_q <= 1'b0;
          end else if (st == S_COLL && stop) begin
            if (abort_q || cnt_q == '0) st <= S_IDLE;
            else begin
              st    <= S_PROG;
              idx_q <= '0;
              tk_q  <= '0;
            end
          end else if (st == S_COLL && data_vld) begin
            if (over) abort_q <= 1'b1;
            else if (!abort_q) begin
              slot_q <= slot_q + LO_W'(1);
              if (!full) cnt_q <= cnt_q + CNT_W'(1);
            end
          end
        end
        S_PROG: begin
          if (unit_end) begin
            tk_q  <= '0;
            idx_q <= idx_q + LO_W'(1);
            if (last_byte) st <= S_GAP;
          end else begin
            tk_q <= tk_q + TK_W'(1);
          end
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  p_we_in_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> busy);
  p_hi_fixed_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy)) |-> $stable(mem_addr[ADDR_W-1:LO_W]));
  p_abort_noack_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ((OVF_WRAP == 0) && in_coll && data_vld && full) |-> !data_ack);
  p_empty_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ((st == S_COLL) && stop && !xfer_start && cnt_q == '0) |=> !busy);
  p_protect_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_we && (PROT_EN != 0) && wp) |-> !mem_addr[ADDR_W-1]);
  p_busy_noack_r9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !data_ack);
  p_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> (st == S_GAP && !data_ack));
endmodule

// File: tb/page_prog_seq_tb.sv
`timescale 1ns/1ps
module page_prog_seq_tb;
  localparam int T = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic xfer_start = 1'b0, data_vld = 1'b0, stop = 1'b0, wp = 1'b0;
  logic [8:0] start_addr = '0;
  logic [7:0] data_in = '0;
  logic ack_l, busy_l, we_l, ack_s, busy_s, we_s;
  logic [8:0] addr_l;
  logic [7:0] addr_s, wd_l, wd_s;

  always #5 clk = ~clk;

  page_prog_seq #(.ADDR_W(9), .PAGE_BYTES(8), .OVF_WRAP(1), .PROT_EN(1), .TICKS_PER_BYTE(T)) u_dut (
    .clk(clk), .rst_n(rst_n), .xfer_start(xfer_start), .start_addr(start_addr),
    .data_vld(data_vld), .data_in(data_in), .stop(stop), .wp(wp),
    .data_ack(ack_l), .busy(busy_l), .mem_we(we_l), .mem_addr(addr_l), .mem_wdata(wd_l));

  page_prog_seq #(.ADDR_W(8), .PAGE_BYTES(2), .OVF_WRAP(0), .PROT_EN(1), .TICKS_PER_BYTE(T)) u_dut_s (
    .clk(clk), .rst_n(rst_n), .xfer_start(xfer_start), .start_addr(start_addr[7:0]),
    .data_vld(data_vld), .data_in(data_in), .stop(stop), .wp(wp),
    .data_ack(ack_s), .busy(busy_s), .mem_we(we_s), .mem_addr(addr_s), .mem_wdata(wd_s));

  int checks = 0, fails = 0;
  bit done = 0;
  logic [7:0] arr_l [512], exp_l [512];
  logic [7:0] arr_s [256], exp_s [256];
  logic [7:0] dat [16];
  int bcnt_l, bcnt_s, acks_l, acks_s;

  always @(negedge clk) begin
    if (we_l) arr_l[addr_l] = wd_l;
    if (we_s) arr_s[addr_s] = wd_s;
    if (busy_l) bcnt_l++;
    if (busy_s) bcnt_s++;
  end

  task automatic chk(input string tag, input string what, input int act, input int expv);
    checks++;
    if (act != expv) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, expv);
    end
  endtask

  function automatic int min_i(input int a, input int b);
    return (a < b) ? a : b;
  endfunction

  task automatic model(input logic [8:0] a, input int n, input logic w);
    int eff;
    logic [8:0] ad;
    logic [7:0] as;
    eff = min_i(n, 8);
    for (int i = 0; i < eff; i++) begin
      ad = {a[8:3], 3'(a[2:0] + 3'(i))};
      if (!(w && ad[8])) exp_l[ad] = dat[i + 8 * ((n - 1 - i) / 8)];
    end
    if (n <= 2)
      for (int i = 0; i < n; i++) begin
        as = {a[7:1], 1'(a[0] + 1'(i))};
        if (!(w && as[7])) exp_s[as] = dat[i];
      end
  endtask

  task automatic cmp_mem(input string tag);
    int bad_l = 0, bad_s = 0;
    for (int i = 0; i < 512; i++) if (arr_l[i] !== exp_l[i]) bad_l++;
    for (int i = 0; i < 256; i++) if (arr_s[i] !== exp_s[i]) bad_s++;
    chk(tag, "wrap-variant array mismatches", bad_l, 0);
    chk(tag, "abort-variant array mismatches", bad_s, 0);
  endtask

  task automatic wait_idle();
    @(negedge clk);
    @(negedge clk);
    while (busy_l || busy_s) @(negedge clk);
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic xfer(input string tag, input logic [8:0] a, input int n, input logic w, input bit gaps);
    bcnt_l = 0; bcnt_s = 0; acks_l = 0; acks_s = 0;
    @(negedge clk);
    wp = w; xfer_start = 1'b1; start_addr = a;
    @(negedge clk);
    xfer_start = 1'b0;
    for (int k = 0; k < n; k++) begin
      data_vld = 1'b1; data_in = dat[k];
      #1;
      if (ack_l) acks_l++;
      if (ack_s) acks_s++;
      @(negedge clk);
      data_vld = 1'b0;
      if (gaps && $urandom_range(0, 1) == 1) @(negedge clk);
    end
    stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    wait_idle();
    model(a, n, w);
    chk(tag, "wrap-variant acks", acks_l, n);
    chk((n > 2) ? "R6" : tag, "abort-variant acks", acks_s, min_i(n, 2));
    chk("R3", "wrap-variant busy cycles", bcnt_l, min_i(n, 8) * T);
    chk((n > 2) ? "R6" : "R3", "abort-variant busy cycles", bcnt_s, (n <= 2) ? n * T : 0);
    cmp_mem(tag);
  endtask

  function automatic string pick_tag(input logic [8:0] a, input int n, input logic w);
    if (n == 0) return "R7";
    if (n > 8) return "R5";
    if (w && a[8]) return "R8";
    if (int'(a[2:0]) + n > 8) return "R4";
    if (n == 1) return "R2";
    return "R1";
  endfunction

  initial begin
    #1500000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int unsigned sd;
    logic [8:0] ra;
    int rn;
    logic rw;
    sd = $urandom(32'd2024);
    for (int i = 0; i < 512; i++) begin arr_l[i] = 8'h00; exp_l[i] = 8'h00; end
    for (int i = 0; i < 256; i++) begin arr_s[i] = 8'h00; exp_s[i] = 8'h00; end
    repeat (3) @(negedge clk);
    chk("R10", "busy after reset", int'(busy_l) + int'(busy_s), 0);
    chk("R10", "write enable after reset", int'(we_l) + int'(we_s), 0);
    chk("R10", "ack after reset", int'(ack_l) + int'(ack_s), 0);
    rst_n = 1'b1;

    for (int k = 0; k < 16; k++) dat[k] = 8'(k * 17 + 3);
    xfer("R2", 9'h012, 1, 1'b0, 0);
    xfer("R1", 9'h040, 2, 1'b0, 0);
    xfer("R7", 9'h050, 0, 1'b0, 0);
    xfer("R6", 9'h060, 3, 1'b0, 0);
    xfer("R4", 9'h0A5, 8, 1'b0, 0);
    for (int k = 0; k < 16; k++) dat[k] = 8'($urandom);
    xfer("R5", 9'h133, 11, 1'b0, 0);
    xfer("R8", 9'h1FE, 2, 1'b1, 0);
    xfer("R8", 9'h07E, 2, 1'b1, 0);

    dat[0] = 8'h5A;
    bcnt_l = 0; bcnt_s = 0;
    @(negedge clk);
    xfer_start = 1'b1; start_addr = 9'h021;
    @(negedge clk);
    xfer_start = 1'b0; data_vld = 1'b1; data_in = dat[0];
    @(negedge clk);
    data_vld = 1'b0; stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    @(negedge clk);
    xfer_start = 1'b1; start_addr = 9'h0C0;
    @(negedge clk);
    xfer_start = 1'b0; data_vld = 1'b1; data_in = 8'hEE;
    #1;
    chk("R9", "ack while busy", int'(ack_l) + int'(ack_s), 0);
    @(negedge clk);
    data_vld = 1'b0; stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    while (busy_l) @(negedge clk);
    xfer_start = 1'b1; start_addr = 9'h0C8;
    @(negedge clk);
    xfer_start = 1'b0; data_vld = 1'b1; data_in = 8'hDD;
    #1;
    chk("R9", "ack after start in idle gap", int'(ack_l) + int'(ack_s), 0);
    @(negedge clk);
    data_vld = 1'b0; stop = 1'b1;
    @(negedge clk);
    stop = 1'b0;
    repeat (T + 4) @(negedge clk);
    model(9'h021, 1, 1'b0);
    chk("R9", "wrap-variant busy cycles with ignored requests", bcnt_l, T);
    chk("R9", "abort-variant busy cycles with ignored requests", bcnt_s, T);
    cmp_mem("R9");

    for (int t = 0; t < 40; t++) begin
      ra = 9'($urandom);
      rn = $urandom_range(0, 11);
      rw = 1'($urandom_range(0, 1));
      for (int k = 0; k < 16; k++) dat[k] = 8'($urandom);
      xfer(pick_tag(ra, rn, rw), ra, rn, rw, 1);
    end

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule